// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell

This block sits behind one OR sum of a programmable sum-of-products array. It turns that sum into a value for a three-state pin, and it returns a feedback signal to the array. A two-bit mode chooses where the pin value comes from: either a D flip-flop that samples the sum, or the sum itself taken straight through. The same mode also sets the output polarity to active-high or active-low. A per-output enable term decides whether the pin is driven or left floating.

The flip-flop has two global terms shared by every cell of the array. The preset term takes effect on the next clock edge. The clear term acts at once and does not wait for the clock, and it wins over the preset. A power-on reset input clears the flip-flop in the same asynchronous way.

The feedback source depends on the mode. In a registered mode the array sees the flip-flop output before polarity inversion. In a combinational mode the array sees whatever value is on the pin, so the pin can act as an input or as a bidirectional line. The pin is modelled as a driven value with an enable flag, and the value on the pin comes back in as a separate input.

Top module: `out_cell`

## Requirements
- R1: While `rst_n` is low the flip-flop is cleared, so in mode `cfg_a_i`=1, `cfg_b_i`=0 both `pin_o` and `fb_o` read 0.
- R2: With preset and clear both false, each rising clock edge loads `sum_i` into the flip-flop.
- R3: When `preset_i` is high and `clear_i` is low at a rising edge, the flip-flop becomes 1 after that edge, whatever the value of `sum_i`.
- R4: When `clear_i` goes high, the flip-flop drops to 0 straight away, without waiting for a clock edge.
- R5: When `preset_i` and `clear_i` are both high, the flip-flop ends at 0.
- R6: Mode `cfg_a_i`=1, `cfg_b_i`=0 is registered active-high: `pin_o` equals the flip-flop output.
- R7: Mode `cfg_a_i`=0, `cfg_b_i`=0 is registered active-low: `pin_o` is the inverse of the flip-flop output.
- R8: Mode `cfg_a_i`=1, `cfg_b_i`=1 is combinational active-high: `pin_o` follows `sum_i` in the same cycle, with no clock edge needed.
- R9: Mode `cfg_a_i`=0, `cfg_b_i`=1 is combinational active-low: `pin_o` is the inverse of `sum_i`.
- R10: When `cfg_b_i`=0, `fb_o` is the flip-flop output before inversion. When `cfg_b_i`=1, `fb_o` is `pin_i`.
- R11: `pin_oe_o` is high exactly when `oe_term_i` is high; otherwise the pin is floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| rst_n | input | 1 | Power-on reset, active low, clears the flip-flop asynchronously |
| sum_i | input | 1 | OR sum from the array |
| oe_term_i | input | 1 | Output enable product term |
| preset_i | input | 1 | Global synchronous preset term |
| clear_i | input | 1 | Global asynchronous clear term |
| cfg_a_i | input | 1 | Polarity select: 1 = active-high |
| cfg_b_i | input | 1 | Type select: 1 = combinational |
| pin_i | input | 1 | Value currently on the pin |
| pin_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
Results from the flip-flop (R2, R3, R5, R6, R7 and the registered branch of R10) are due one rising edge after the inputs are applied. Combinational results (R8, R9, R11 and the pin branch of R10) are due as soon as the inputs settle. The clear (R4) must act between edges, without waiting for a clock.

Inputs change 2 ns after a falling edge. The driver queues the expected result, and the monitor compares it at the following falling edge, which comes after exactly one rising edge. The asynchronous clear and the same-cycle combinational path are also sampled 1 ns after the input changes, before any clock edge.

// File: rtl/out_cell.sv
module out_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_i,
  input  logic oe_term_i,
  input  logic preset_i,
  input  logic clear_i,
  input  logic cfg_a_i,
  input  logic cfg_b_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o
);

  logic q;
  logic clr_async;
  logic sel;

  assign clr_async = ~rst_n | clear_i;

  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)     q <= 1'b0;
    else if (preset_i) q <= 1'b1;
    else               q <= sum_i;
  end

  assign sel      = cfg_b_i ? sum_i : q;
  assign pin_o    = cfg_a_i ? sel : ~sel;
  assign pin_oe_o = oe_term_i;
  assign fb_o     = cfg_b_i ? pin_i : q;

endmodule

module out_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic sum_i,
  input logic oe_term_i,
  input logic preset_i,
  input logic clear_i,
  input logic cfg_a_i,
  input logic cfg_b_i,
  input logic pin_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic fb_o
);

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_i && !clear_i) |=> (clear_i || cfg_b_i || fb_o == $past(sum_i))); // R2

  AST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_i && !clear_i) |=> (clear_i || cfg_b_i || fb_o)); // R3

  AST_CLEAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (cfg_b_i || !fb_o)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_i && clear_i) |=> (cfg_b_i || !fb_o)); // R5

  AST_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_a_i && !cfg_b_i) |-> (fb_o != pin_o)); // R7

  AST_REG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a_i && !cfg_b_i) |-> (fb_o == pin_o)); // R6

  AST_COMB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a_i && cfg_b_i) |-> (pin_o == sum_i)); // R8

  AST_PIN_FB: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_b_i |-> (fb_o == pin_i)); // R10

  AST_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_term_i) |-> pin_oe_o); // R11

endmodule

bind out_cell out_cell_chk u_chk (.*);

// File: tb/out_cell_tb.sv
module out_cell_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sum_i = 1'b0, oe_term_i = 1'b0, preset_i = 1'b0, clear_i = 1'b0;
  logic cfg_a_i = 1'b1, cfg_b_i = 1'b0, pin_i = 1'b0;
  logic pin_o, pin_oe_o, fb_o;

  int n_run = 0;
  int n_fail = 0;
  logic q_ref = 1'b0;
  bit done = 0;

  typedef struct {
    string tag;
    logic  po;
    logic  poe;
    logic  fb;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  out_cell u_dut (
    .clk(clk), .rst_n(rst_n), .sum_i(sum_i), .oe_term_i(oe_term_i),
    .preset_i(preset_i), .clear_i(clear_i), .cfg_a_i(cfg_a_i), .cfg_b_i(cfg_b_i),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: apply one set of inputs after a falling edge, queue what is due after the next rising edge
  task automatic step(input string tag, input logic a, input logic b, input logic s,
                      input logic pr, input logic cl, input logic oe, input logic pi);
    exp_t e;
    logic sel;
    @(negedge clk);
    #2;
    cfg_a_i = a; cfg_b_i = b; sum_i = s; preset_i = pr; clear_i = cl;
    oe_term_i = oe; pin_i = pi;
    if (cl)      q_ref = 1'b0;
    else if (pr) q_ref = 1'b1;
    else         q_ref = s;
    sel   = b ? s : q_ref;
    e.tag = tag;
    e.po  = a ? sel : ~sel;
    e.poe = oe;
    e.fb  = b ? pi : q_ref;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "pin_o", pin_o, e.po);
        chk(e.tag, "pin_oe_o", pin_oe_o, e.poe);
        chk(e.tag, "fb_o", fb_o, e.fb);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sum_i = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "pin_o in reset", pin_o, 1'b0);
    chk("R1", "fb_o in reset", fb_o, 1'b0);
    @(negedge clk);
    #2 rst_n = 1'b1;

    step("R6",  1, 0, 1, 0, 0, 1, 0);
    step("R2",  1, 0, 0, 0, 0, 1, 1);
    step("R7",  0, 0, 1, 0, 0, 1, 0);
    step("R7",  0, 0, 0, 0, 0, 1, 1);
    step("R3",  1, 0, 0, 1, 0, 1, 0);
    step("R3",  0, 0, 0, 1, 0, 1, 0);
    step("R5",  1, 0, 1, 1, 1, 1, 0);
    step("R2",  1, 0, 1, 0, 0, 1, 0);

    // R4: clear drops the flip-flop between edges
    @(negedge clk);
    @(negedge clk);
    #2 clear_i = 1'b1;
    #1;
    chk("R4", "pin_o after clear", pin_o, 1'b0);
    chk("R4", "fb_o after clear", fb_o, 1'b0);
    q_ref = 1'b0;
    step("R4",  1, 0, 1, 0, 1, 1, 0);

    step("R8",  1, 1, 1, 0, 0, 1, 0);
    step("R10", 1, 1, 0, 0, 0, 1, 1);
    step("R9",  0, 1, 1, 0, 0, 1, 1);
    step("R9",  0, 1, 0, 0, 0, 0, 0);
    step("R11", 1, 0, 1, 0, 0, 0, 0);
    step("R11", 1, 0, 1, 0, 0, 1, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 1);

    // R8: combinational path follows the sum with no clock edge
    @(negedge clk);
    @(negedge clk);
    #2 cfg_a_i = 1'b1; cfg_b_i = 1'b1; sum_i = 1'b0;
    #1 chk("R8", "pin_o same cycle low", pin_o, 1'b0);
    sum_i = 1'b1;
    #1 chk("R8", "pin_o same cycle high", pin_o, 1'b1);
    cfg_a_i = 1'b0;
    #1 chk("R9", "pin_o same cycle inverted", pin_o, 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule